// File: doc/BRIEF.md
# Four-Thread Event-Driven Issue Selector

This block decides which of four hardware threads owns a shared in-order execution pipeline in each cycle. Every thread reports two flags: a ready flag from the fetch side (its instruction buffer holds at least one instruction) and a stall flag from the pipeline (its next instruction is blocked by a dependency). A thread is eligible when it is ready and not stalled. The selector keeps the thread that currently owns the pipeline for as long as that thread stays eligible. It moves to another thread only when the owner stalls or drains its buffer. There is no time slicing.

When a switch is needed, the new owner is the first eligible thread in circular order after the current one, so every waiting thread is reached in turn. Because each thread has its own register-file bank, the block drives a one-hot bank select that always matches the owning thread. When ownership moves, a one-cycle swap strobe carries the outgoing thread number, so that thread's state can be written back. When no thread is eligible, the block raises an idle flag and keeps the last owner selected.

All decisions are registered. Flags sampled at a rising clock edge take effect on the outputs right after that edge.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset the selected thread is 0, the bank select is 4'b0001, idle is 1 and the swap strobe is 0.
- R2: The bank select is one-hot, and bit i is set exactly when thread i is selected.
- R3: While the selected thread is ready and not stalled, it stays selected and no swap strobe is raised, even if other threads are eligible.
- R4: When the selected thread is stalled and another thread is eligible, selection moves to an eligible thread.
- R5: When the selected thread is not ready (empty buffer) and another thread is eligible, selection moves to an eligible thread.
- R6: Only a thread with ready=1 and stall=0 can become the new selection; ready but stalled threads are skipped.
- R7: The new selection is the first eligible thread in the order cur+1, cur+2, cur+3 (modulo 4).
- R8: When no thread is eligible, idle is 1, the selection holds and no swap strobe is raised. If the held thread becomes eligible again, it resumes with no swap strobe.
- R9: On every change of selection, swap_vld_o is 1 for exactly that one cycle and swap_tid_o holds the outgoing thread number. This happens in the same cycle as the new selection appears.
- R10: Flags sampled at a rising edge change the outputs only after that edge, not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready_i | input | 4 | Per-thread flag: fetched instructions available |
| stall_i | input | 4 | Per-thread flag: next instruction blocked by a dependency |
| sel_tid_o | output | 2 | Thread that owns the pipeline |
| bank_sel_o | output | 4 | One-hot register-file bank select |
| idle_o | output | 1 | No thread was eligible at the last decision |
| swap_vld_o | output | 1 | One-cycle strobe: a thread was swapped out |
| swap_tid_o | output | 2 | Number of the thread swapped out |

## Verification
A sequence of flag patterns drives the selector through several cases: all threads eligible, which separates retention from rotation; a stalled owner and an empty owner, which separate the two switch triggers; and ready-but-stalled neighbours, which show whether stall masks eligibility. Wrap-around searches from thread 3 and from thread 2 test the circular order. Runs of no eligible thread show idle, hold and the resume without a strobe. Directed tests sample just before an edge to expose any combinational path, and assert reset in the middle of a run.

// File: rtl/thread_sel_pkg.sv
package thread_sel_pkg;
  // Circular thread index: (cur + off) modulo n
  function automatic int wrap_add(input int cur, input int off, input int n);
    return (cur + off) % n;
  endfunction
endpackage

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick
  import thread_sel_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic [TW-1:0] cur,
  output logic          found,
  output logic [TW-1:0] pick
);
  // Search farthest first so the nearest eligible successor wins (R7)
  always_comb begin
    found = 1'b0;
    pick  = cur;
    for (int off = N - 1; off >= 1; off--) begin
      if (elig[wrap_add(int'(cur), off, N)]) begin
        found = 1'b1;
        pick  = TW'(wrap_add(int'(cur), off, N));
      end
    end
  end

  assert_pick_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pick != cur) && elig[pick]);
endmodule

// File: rtl/tsel_state.sv
module tsel_state #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          keep,
  input  logic          found,
  input  logic [TW-1:0] pick,
  output logic [TW-1:0] cur_q,
  output logic          idle_q,
  output logic          swap_vld_q,
  output logic [TW-1:0] swap_tid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      idle_q     <= 1'b1;
      swap_vld_q <= 1'b0;
      swap_tid_q <= '0;
    end else begin
      swap_vld_q <= 1'b0;
      if (keep) begin
        idle_q <= 1'b0;
      end else if (found) begin
        cur_q      <= pick;
        idle_q     <= 1'b0;
        swap_vld_q <= 1'b1;
        swap_tid_q <= cur_q;
      end else begin
        idle_q <= 1'b1;
      end
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_vld_q |=> !swap_vld_q || $changed(cur_q));
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ready_i,
  input  logic [N-1:0]  stall_i,
  output logic [TW-1:0] sel_tid_o,
  output logic [N-1:0]  bank_sel_o,
  output logic          idle_o,
  output logic          swap_vld_o,
  output logic [TW-1:0] swap_tid_o
);
  // Named internal events
  logic [N-1:0]  elig;
  logic          keep;
  logic          found;
  logic [TW-1:0] pick;
  logic [TW-1:0] cur_q;
  logic [N-1:0]  prev_elig_q;
  logic          started_q;

  assign elig = ready_i & ~stall_i;
  assign keep = elig[cur_q];

  tsel_rr_pick #(.N(N), .TW(TW)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .cur(cur_q),
    .found(found), .pick(pick)
  );

  tsel_state #(.N(N), .TW(TW)) u_state (
    .clk(clk), .rst_n(rst_n), .keep(keep), .found(found), .pick(pick),
    .cur_q(cur_q), .idle_q(idle_o), .swap_vld_q(swap_vld_o),
    .swap_tid_q(swap_tid_o)
  );

  assign sel_tid_o = cur_q;

  for (genvar g = 0; g < N; g++) begin : g_bank
    assign bank_sel_o[g] = (cur_q == TW'(g));
  end

  // Observation registers for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_elig_q <= '0;
      started_q   <= 1'b0;
    end else begin
      prev_elig_q <= elig;
      started_q   <= 1'b1;
    end
  end

  assert_bank_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bank_sel_o) && bank_sel_o[sel_tid_o]);

  assert_keep_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i[sel_tid_o] && !stall_i[sel_tid_o])
      |=> $stable(sel_tid_o) && !swap_vld_o && !idle_o);

  assert_target_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_vld_o |-> prev_elig_q[sel_tid_o]);

  assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && idle_o) |-> (prev_elig_q == '0) && $stable(sel_tid_o) && !swap_vld_o);

  assert_swap_outgoing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_vld_o |-> (swap_tid_o != sel_tid_o) && !idle_o);

  assert_swap_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $changed(sel_tid_o)) |-> swap_vld_o && (swap_tid_o == $past(sel_tid_o)));
endmodule

// File: tb/test_thread_issue_sel.sv
module test_thread_issue_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ready_i = '0;
  logic [3:0] stall_i = '0;
  logic [1:0] sel_tid_o;
  logic [3:0] bank_sel_o;
  logic       idle_o;
  logic       swap_vld_o;
  logic [1:0] swap_tid_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  thread_issue_sel i_thread_issue_sel (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .stall_i(stall_i),
    .sel_tid_o(sel_tid_o), .bank_sel_o(bank_sel_o), .idle_o(idle_o),
    .swap_vld_o(swap_vld_o), .swap_tid_o(swap_tid_o)
  );

  // Layout: req[19:16] ready[15:12] stall[11:8] tid[7:6] idle[5] swap[4] swtid[3:2]
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {4'd8, 4'b0000, 4'b0000, 2'd0, 1'b1, 1'b0, 2'd0, 2'b0}, // R8 nothing eligible
    {4'd8, 4'b0001, 4'b0000, 2'd0, 1'b0, 1'b0, 2'd0, 2'b0}, // R8 resume same, no strobe
    {4'd3, 4'b1111, 4'b0000, 2'd0, 1'b0, 1'b0, 2'd0, 2'b0}, // R3 keep despite others
    {4'd4, 4'b1111, 4'b0001, 2'd1, 1'b0, 1'b1, 2'd0, 2'b0}, // R4 stall switch
    {4'd9, 4'b1111, 4'b0000, 2'd1, 1'b0, 1'b0, 2'd0, 2'b0}, // R9 strobe gone
    {4'd5, 4'b1101, 4'b0000, 2'd2, 1'b0, 1'b1, 2'd1, 2'b0}, // R5 empty switch
    {4'd6, 4'b1111, 4'b1100, 2'd0, 1'b0, 1'b1, 2'd2, 2'b0}, // R6 skip stalled t3
    {4'd7, 4'b0011, 4'b0001, 2'd1, 1'b0, 1'b1, 2'd0, 2'b0}, // R7 next after 0
    {4'd6, 4'b1110, 4'b0110, 2'd3, 1'b0, 1'b1, 2'd1, 2'b0}, // R6 skip stalled t2
    {4'd3, 4'b1001, 4'b0000, 2'd3, 1'b0, 1'b0, 2'd0, 2'b0}, // R3 keep t3
    {4'd7, 4'b0111, 4'b0000, 2'd0, 1'b0, 1'b1, 2'd3, 2'b0}, // R7 wrap 3->0
    {4'd8, 4'b0000, 4'b0000, 2'd0, 1'b1, 1'b0, 2'd0, 2'b0}, // R8 idle hold
    {4'd8, 4'b0000, 4'b0000, 2'd0, 1'b1, 1'b0, 2'd0, 2'b0}, // R8 idle hold
    {4'd9, 4'b0100, 4'b0000, 2'd2, 1'b0, 1'b1, 2'd0, 2'b0}, // R9 leave idle to t2
    {4'd8, 4'b0100, 4'b0100, 2'd2, 1'b1, 1'b0, 2'd0, 2'b0}, // R8 lone thread stalls
    {4'd8, 4'b0100, 4'b0000, 2'd2, 1'b0, 1'b0, 2'd0, 2'b0}  // R8 resume, no strobe
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int tid, input int idle,
                         input int swp, input int swtid);
    chk(req, "sel_tid", int'(sel_tid_o), tid);
    chk("R2", "bank_sel", int'(bank_sel_o), 1 << tid);
    chk(req, "idle", int'(idle_o), idle);
    chk(req, "swap_vld", int'(swap_vld_o), swp);
    if (swp != 0) chk(req, "swap_tid", int'(swap_tid_o), swtid);
  endtask

  task automatic step(input logic [3:0] rdy, input logic [3:0] stl);
    @(negedge clk);
    ready_i = rdy;
    stall_i = stl;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1", 0, 1, 0, 0); // reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:12], VEC[i][11:8]);
      chk_all($sformatf("R%0d", VEC[i][19:16]), int'(VEC[i][7:6]),
              int'(VEC[i][5]), int'(VEC[i][4]), int'(VEC[i][3:2]));
    end

    // R10: new flags must not show on outputs before the edge (owner t2)
    @(negedge clk);
    ready_i = 4'b1111;
    stall_i = 4'b0100;
    #2;
    chk("R10", "sel before edge", int'(sel_tid_o), 2);
    chk("R10", "swap before edge", int'(swap_vld_o), 0);
    @(posedge clk);
    #1;
    chk_all("R4", 3, 0, 1, 2);

    // R7 full circle: owner stalls in turn, each time next in order taken
    step(4'b1111, 4'b1000);
    chk_all("R7", 0, 0, 1, 3);
    step(4'b1111, 4'b0001);
    chk_all("R7", 1, 0, 1, 0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_all("R1", 0, 1, 0, 0);
    @(negedge clk);
    ready_i = 4'b0000;
    stall_i = 4'b0000;
    rst_n = 1'b1;
    step(4'b0010, 4'b0000);
    chk_all("R5", 1, 0, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule